// File: doc/BRIEF.md
# Mask-Driven Candidate Word Generator

This block walks through a keyspace of candidate passwords and hands out one word per clock cycle on a valid/ready stream. The keyspace is defined by a mask: a number of character positions, each with its own short list of allowed characters. Optionally, one position can be replaced by an entry taken from a small word list. In that case the chosen entry is spliced into the word at that position, and the characters to its right shift along.

Software loads the character sets, the list entries and the job shape through a single write port while the block is idle. It then writes a start index and a candidate count and issues a go command. The block turns the start index into per-position offsets, streams exactly the requested number of candidates and raises a last flag on the final one. It then drops back to idle until it is given the next job. A large search is split across several generators by giving each one its own start index and count.

Top module: `mask_word_gen`

## Requirements
- R1: While the consumer holds ready high, a job of N candidates presents valid for exactly N consecutive cycles, with a new word accepted every cycle.
- R2: While valid is high and ready is low, the word and the last flag do not change, and valid stays high.
- R3: Candidate order is an odometer. The rightmost active position advances fastest. A position that passes its final character wraps to its first character and carries one step into its left neighbour. After the final combination the sequence wraps back to the first.
- R4: A write of kind 0 stores the character data[6:0] in position sel[6:4], slot sel[3:0]. A write of kind 1 sets that position's set length to data[7:0], taking the position from sel[2:0]. A position shows the character in the slot equal to its current offset, and a length of 0 behaves as 1.
- R5: A write of kind 5 sets the start index and a write of kind 6 sets the count. The first candidate is the one whose mixed-radix offsets, with the rightmost position least significant, equal the start index modulo the keyspace size.
- R6: The last flag is high only on the final candidate of a job. After that candidate is accepted, valid stays low.
- R7: A go command (kind 7) issued with a count of zero produces no output.
- R8: A write of kind 4 sets the job shape: active positions from data[7:0], list position from data[15:8], list enable from data[16] and list entry count from data[31:24]. A write of kind 2 stores a list character, with the entry in sel[6:3] and the character index in sel[2:0]. A write of kind 3 sets an entry's length from data[7:0], taking the entry from sel[3:0]. When the list is enabled, the offset at the list position selects a list entry, and that entry's characters are placed there in full. The remaining mask characters follow after it, and the word is cut to 8 characters.
- R9: Configuration writes made while a job is running have no effect on that job or on later jobs.
- R10: After reset, valid and last are low. The output word packs character k into bits [7k+6:7k], and unused slots hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_kind_i | input | 3 | Write kind (0..7) |
| cfg_sel_i | input | 8 | Position/slot/entry selector |
| cfg_data_i | input | 32 | Write data |
| ready_i | input | 1 | Consumer accepts the current word |
| word_o | output | 56 | Candidate word, 8 characters of 7 bits, slot 0 at the LSBs |
| valid_o | output | 1 | Word is valid |
| last_o | output | 1 | Final word of the job |

## Verification
The assertions assume that every set length and the list entry count are at most 16, and that every list entry length is at most 8. They also assume that the shape never names more than 8 positions. Under those assumptions every stored offset stays below its position's radix. The stimulus loads only strings that fit these depths and uses shapes of 3 or 4 positions with list counts of 3 and 4. It also issues configuration writes during a run only to check that they are ignored.

// File: rtl/mwg_pkg.sv
package mwg_pkg;
  typedef enum logic [2:0] {
    CFG_CHAR  = 3'd0,
    CFG_RLEN  = 3'd1,
    CFG_LCHAR = 3'd2,
    CFG_LLEN  = 3'd3,
    CFG_SHAPE = 3'd4,
    CFG_START = 3'd5,
    CFG_COUNT = 3'd6,
    CFG_GO    = 3'd7
  } cfg_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEED = 2'd1,
    ST_RUN  = 2'd2
  } gen_state_e;
endpackage

// File: rtl/mwg_cfg.sv
module mwg_cfg
  import mwg_pkg::*;
#(
  parameter int unsigned NUM_POS     = 8,
  parameter int unsigned CHAR_W      = 7,
  parameter int unsigned RANGE_DEPTH = 16,
  parameter int unsigned LIST_DEPTH  = 16,
  parameter int unsigned LIST_CHARS  = 8,
  parameter int unsigned SEL_W       = 8,
  parameter int unsigned CFG_W       = 32
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  we_i,
  input  logic [2:0]                            kind_i,
  input  logic [SEL_W-1:0]                      sel_i,
  input  logic [CFG_W-1:0]                      data_i,
  input  logic                                  idle_i,
  output logic [CHAR_W-1:0]                     rchar_o [NUM_POS][RANGE_DEPTH],
  output logic [$clog2((RANGE_DEPTH > LIST_DEPTH ? RANGE_DEPTH : LIST_DEPTH)+1)-1:0] rlen_o [NUM_POS],
  output logic [CHAR_W-1:0]                     lchar_o [LIST_DEPTH][LIST_CHARS],
  output logic [$clog2(LIST_CHARS+1)-1:0]       llen_o [LIST_DEPTH],
  output logic [$clog2(NUM_POS+1)-1:0]          npos_o,
  output logic [$clog2(NUM_POS)-1:0]            lpos_o,
  output logic                                  len_o,
  output logic [$clog2((RANGE_DEPTH > LIST_DEPTH ? RANGE_DEPTH : LIST_DEPTH)+1)-1:0] lcnt_o,
  output logic [CFG_W-1:0]                      start_o,
  output logic [CFG_W-1:0]                      count_o,
  output logic                                  go_o
);
  localparam int unsigned MAXR   = (RANGE_DEPTH > LIST_DEPTH) ? RANGE_DEPTH : LIST_DEPTH;
  localparam int unsigned RAD_W  = $clog2(MAXR+1);
  localparam int unsigned POS_W  = $clog2(NUM_POS);
  localparam int unsigned NP_W   = $clog2(NUM_POS+1);
  localparam int unsigned SLOT_W = $clog2(RANGE_DEPTH);
  localparam int unsigned ENT_W  = $clog2(LIST_DEPTH);
  localparam int unsigned LC_W   = $clog2(LIST_CHARS);
  localparam int unsigned LL_W   = $clog2(LIST_CHARS+1);

  logic wr_ok;
  assign wr_ok = we_i && idle_i;
  assign go_o  = wr_ok && (cfg_kind_e'(kind_i) == CFG_GO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rchar_o <= '{default: '0};
      rlen_o  <= '{default: '0};
      lchar_o <= '{default: '0};
      llen_o  <= '{default: '0};
      npos_o  <= '0;
      lpos_o  <= '0;
      len_o   <= 1'b0;
      lcnt_o  <= '0;
      start_o <= '0;
      count_o <= '0;
    end else if (wr_ok) begin
      case (cfg_kind_e'(kind_i))
        CFG_CHAR:  rchar_o[sel_i[SLOT_W +: POS_W]][sel_i[SLOT_W-1:0]] <= data_i[CHAR_W-1:0];
        CFG_RLEN:  rlen_o[sel_i[POS_W-1:0]] <= data_i[RAD_W-1:0];
        CFG_LCHAR: lchar_o[sel_i[LC_W +: ENT_W]][sel_i[LC_W-1:0]] <= data_i[CHAR_W-1:0];
        CFG_LLEN:  llen_o[sel_i[ENT_W-1:0]] <= data_i[LL_W-1:0];
        CFG_SHAPE: begin
          npos_o <= data_i[NP_W-1:0];
          lpos_o <= data_i[8 +: POS_W];
          len_o  <= data_i[16];
          lcnt_o <= data_i[24 +: RAD_W];
        end
        CFG_START: start_o <= data_i;
        CFG_COUNT: count_o <= data_i;
        default: ;
      endcase
    end
  end

  // job parameters must not move while a job is in flight
  assert_cfg_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_i && !$past(idle_i)) |-> ($stable(npos_o) && $stable(start_o) && $stable(lcnt_o)));
endmodule

// File: rtl/mwg_odometer.sv
module mwg_odometer #(
  parameter int unsigned NUM_POS = 8,
  parameter int unsigned MAXR    = 16,
  parameter int unsigned CFG_W   = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          seed_i,
  input  logic [CFG_W-1:0]              idx_i,
  input  logic                          step_i,
  input  logic                          run_i,
  input  logic [$clog2(NUM_POS+1)-1:0]  npos_i,
  input  logic [$clog2(MAXR+1)-1:0]     radix_i [NUM_POS],
  output logic [$clog2(MAXR)-1:0]       dig_o [NUM_POS],
  output logic                          seed_done_o
);
  localparam int unsigned RAD_W = $clog2(MAXR+1);
  localparam int unsigned DIG_W = $clog2(MAXR);
  localparam int unsigned POS_W = $clog2(NUM_POS);
  localparam int unsigned NP_W  = $clog2(NUM_POS+1);

  logic              seed_act_q;
  logic [POS_W-1:0]  spos_q;
  logic [CFG_W-1:0]  quo_q;
  logic [CFG_W-1:0]  div_q;
  logic [DIG_W-1:0]  nxt [NUM_POS];
  logic              carry;

  assign div_q       = CFG_W'(radix_i[spos_q]);
  assign seed_done_o = seed_act_q && (spos_q == '0);

  // ripple increment, rightmost active position first
  always_comb begin
    carry = 1'b1;
    for (int i = NUM_POS-1; i >= 0; i--) begin
      nxt[i] = dig_o[i];
      if (carry && (i < int'(npos_i))) begin
        if (RAD_W'(dig_o[i]) + RAD_W'(1) >= radix_i[i]) begin
          nxt[i] = '0;
        end else begin
          nxt[i] = dig_o[i] + DIG_W'(1);
          carry  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dig_o      <= '{default: '0};
      seed_act_q <= 1'b0;
      spos_q     <= '0;
      quo_q      <= '0;
    end else if (seed_i) begin
      dig_o      <= '{default: '0};
      quo_q      <= idx_i;
      spos_q     <= POS_W'(NUM_POS-1);
      seed_act_q <= 1'b1;
    end else if (seed_act_q) begin
      // one mixed-radix digit per cycle, least significant first
      if (NP_W'(spos_q) < npos_i) begin
        dig_o[spos_q] <= DIG_W'(quo_q % div_q);
        quo_q         <= quo_q / div_q;
      end
      spos_q <= spos_q - POS_W'(1);
      if (spos_q == '0) seed_act_q <= 1'b0;
    end else if (step_i) begin
      dig_o <= nxt;
    end
  end

  for (genvar g = 0; g < NUM_POS; g++) begin : g_chk
    assert_digit_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && (NP_W'(g) < npos_i)) |-> (RAD_W'(dig_o[g]) < radix_i[g]));
  end
endmodule

// File: rtl/mwg_assemble.sv
module mwg_assemble #(
  parameter int unsigned NUM_POS     = 8,
  parameter int unsigned CHAR_W      = 7,
  parameter int unsigned RANGE_DEPTH = 16,
  parameter int unsigned LIST_DEPTH  = 16,
  parameter int unsigned LIST_CHARS  = 8,
  parameter int unsigned OUT_CHARS   = 8
) (
  input  logic [$clog2((RANGE_DEPTH > LIST_DEPTH ? RANGE_DEPTH : LIST_DEPTH))-1:0] dig_i [NUM_POS],
  input  logic [CHAR_W-1:0]               rchar_i [NUM_POS][RANGE_DEPTH],
  input  logic [CHAR_W-1:0]               lchar_i [LIST_DEPTH][LIST_CHARS],
  input  logic [$clog2(LIST_CHARS+1)-1:0] llen_i [LIST_DEPTH],
  input  logic [$clog2(NUM_POS+1)-1:0]    npos_i,
  input  logic [$clog2(NUM_POS)-1:0]      lpos_i,
  input  logic                            list_act_i,
  output logic [OUT_CHARS*CHAR_W-1:0]     word_o
);
  localparam int unsigned SLOT_W = $clog2(RANGE_DEPTH);
  localparam int unsigned ENT_W  = $clog2(LIST_DEPTH);
  localparam int unsigned LC_W   = $clog2(LIST_CHARS);
  localparam int unsigned POS_W  = $clog2(NUM_POS);

  logic [CHAR_W-1:0] mch [NUM_POS];
  logic [ENT_W-1:0]  lsel;

  for (genvar p = 0; p < NUM_POS; p++) begin : g_mch
    assign mch[p] = rchar_i[p][dig_i[p][SLOT_W-1:0]];
  end

  assign lsel = dig_i[lpos_i][ENT_W-1:0];

  always_comb begin
    int lw, lp, src;
    logic [CHAR_W-1:0] c;
    lw     = int'(llen_i[lsel]);
    lp     = int'(lpos_i);
    word_o = '0;
    for (int k = 0; k < OUT_CHARS; k++) begin
      c = '0;
      if (!list_act_i || k < lp) begin
        src = k;
      end else if (k < lp + lw) begin
        src = -1;
        if (k - lp < LIST_CHARS) c = lchar_i[lsel][LC_W'(k - lp)];
      end else begin
        src = k - lw + 1;   // mask positions after the spliced entry
      end
      if (src >= 0 && src < int'(npos_i) && src < NUM_POS) c = mch[POS_W'(src)];
      word_o[k*CHAR_W +: CHAR_W] = c;
    end
  end
endmodule

// File: rtl/mask_word_gen.sv
module mask_word_gen
  import mwg_pkg::*;
#(
  parameter int unsigned NUM_POS     = 8,
  parameter int unsigned CHAR_W      = 7,
  parameter int unsigned RANGE_DEPTH = 16,
  parameter int unsigned LIST_DEPTH  = 16,
  parameter int unsigned LIST_CHARS  = 8,
  parameter int unsigned OUT_CHARS   = 8,
  parameter int unsigned SEL_W       = 8,
  parameter int unsigned CFG_W       = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cfg_we_i,
  input  logic [2:0]                  cfg_kind_i,
  input  logic [SEL_W-1:0]            cfg_sel_i,
  input  logic [CFG_W-1:0]            cfg_data_i,
  input  logic                        ready_i,
  output logic [OUT_CHARS*CHAR_W-1:0] word_o,
  output logic                        valid_o,
  output logic                        last_o
);
  localparam int unsigned MAXR  = (RANGE_DEPTH > LIST_DEPTH) ? RANGE_DEPTH : LIST_DEPTH;
  localparam int unsigned RAD_W = $clog2(MAXR+1);
  localparam int unsigned DIG_W = $clog2(MAXR);
  localparam int unsigned POS_W = $clog2(NUM_POS);
  localparam int unsigned NP_W  = $clog2(NUM_POS+1);
  localparam int unsigned LL_W  = $clog2(LIST_CHARS+1);

  gen_state_e        state_q;
  logic [CFG_W-1:0]  remain_q;

  logic [CHAR_W-1:0] rchar [NUM_POS][RANGE_DEPTH];
  logic [RAD_W-1:0]  rlen  [NUM_POS];
  logic [CHAR_W-1:0] lchar [LIST_DEPTH][LIST_CHARS];
  logic [LL_W-1:0]   llen  [LIST_DEPTH];
  logic [NP_W-1:0]   npos;
  logic [POS_W-1:0]  lpos;
  logic              len;
  logic [RAD_W-1:0]  lcnt;
  logic [CFG_W-1:0]  start_idx, count;
  logic              go, seed, seed_done, step, list_act, idle;
  logic [RAD_W-1:0]  radix [NUM_POS];
  logic [DIG_W-1:0]  dig   [NUM_POS];

  assign idle     = (state_q == ST_IDLE);
  assign list_act = len && (NP_W'(lpos) < npos);
  assign seed     = go && (count != '0);
  assign valid_o  = (state_q == ST_RUN);
  assign last_o   = valid_o && (remain_q == CFG_W'(1));
  assign step     = valid_o && ready_i;

  for (genvar i = 0; i < NUM_POS; i++) begin : g_rad
    logic [RAD_W-1:0] raw;
    assign raw      = (list_act && (lpos == POS_W'(i))) ? lcnt : rlen[i];
    assign radix[i] = (raw == '0) ? RAD_W'(1) : raw;
  end

  mwg_cfg #(
    .NUM_POS(NUM_POS), .CHAR_W(CHAR_W), .RANGE_DEPTH(RANGE_DEPTH),
    .LIST_DEPTH(LIST_DEPTH), .LIST_CHARS(LIST_CHARS), .SEL_W(SEL_W), .CFG_W(CFG_W)
  ) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .kind_i(cfg_kind_i), .sel_i(cfg_sel_i), .data_i(cfg_data_i),
    .idle_i(idle),
    .rchar_o(rchar), .rlen_o(rlen), .lchar_o(lchar), .llen_o(llen),
    .npos_o(npos), .lpos_o(lpos), .len_o(len), .lcnt_o(lcnt),
    .start_o(start_idx), .count_o(count), .go_o(go)
  );

  mwg_odometer #(.NUM_POS(NUM_POS), .MAXR(MAXR), .CFG_W(CFG_W)) u_odo (
    .clk_i, .rst_ni,
    .seed_i(seed), .idx_i(start_idx), .step_i(step), .run_i(valid_o),
    .npos_i(npos), .radix_i(radix), .dig_o(dig), .seed_done_o(seed_done)
  );

  mwg_assemble #(
    .NUM_POS(NUM_POS), .CHAR_W(CHAR_W), .RANGE_DEPTH(RANGE_DEPTH),
    .LIST_DEPTH(LIST_DEPTH), .LIST_CHARS(LIST_CHARS), .OUT_CHARS(OUT_CHARS)
  ) u_asm (
    .dig_i(dig), .rchar_i(rchar), .lchar_i(lchar), .llen_i(llen),
    .npos_i(npos), .lpos_i(lpos), .list_act_i(list_act), .word_o(word_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (seed) begin
          state_q  <= ST_SEED;
          remain_q <= count;
        end
        ST_SEED: if (seed_done) state_q <= ST_RUN;
        ST_RUN: if (ready_i) begin
          remain_q <= remain_q - CFG_W'(1);
          if (remain_q == CFG_W'(1)) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_hold_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(word_o) && $stable(last_o)));

  assert_run_unbroken_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && !last_o) |=> valid_o);

  assert_idle_after_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && last_o) |=> !valid_o);

  assert_zero_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && go && (count == '0)) |=> !valid_o && (state_q == ST_IDLE));
endmodule

// File: tb/tb_mask_word_gen.sv
module tb_mask_word_gen;
  localparam int CLK_PERIOD  = 10;
  localparam int NUM_POS     = 8;
  localparam int CHAR_W      = 7;
  localparam int RANGE_DEPTH = 16;
  localparam int LIST_DEPTH  = 16;
  localparam int LIST_CHARS  = 8;
  localparam int OUT_CHARS   = 8;
  localparam int WORD_W      = OUT_CHARS * CHAR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [2:0] kind = '0;
  logic [7:0] sel = '0;
  logic [31:0] data = '0;
  logic ready = 1'b0;
  logic [WORD_W-1:0] word;
  logic valid, last;

  always #(CLK_PERIOD/2) clk = ~clk;

  mask_word_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_kind_i(kind), .cfg_sel_i(sel),
    .cfg_data_i(data), .ready_i(ready), .word_o(word), .valid_o(valid), .last_o(last)
  );

  int compared = 0;
  int mismatched = 0;
  string tag = "R3";
  int ready_mode = 0;

  typedef struct { logic [WORD_W-1:0] w; logic l; } exp_t;
  exp_t exp_q[$];

  int m_rch [NUM_POS][RANGE_DEPTH];
  int m_rlen [NUM_POS];
  int m_lch [LIST_DEPTH][LIST_CHARS];
  int m_llen [LIST_DEPTH];
  int m_npos = 0, m_lpos = 0, m_len = 0, m_lcnt = 0;

  task automatic check(string req, bit ok, string what, logic [63:0] act, logic [63:0] expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [WORD_W-1:0] model_word(longint unsigned idx);
    int r [NUM_POS];
    int d [NUM_POS];
    longint unsigned q;
    bit la;
    int lw, e, j, c;
    logic [WORD_W-1:0] w;
    la = (m_len != 0) && (m_lpos < m_npos);
    for (int i = 0; i < NUM_POS; i++) begin
      r[i] = (la && i == m_lpos) ? m_lcnt : m_rlen[i];
      if (r[i] == 0) r[i] = 1;
      d[i] = 0;
    end
    q = idx;
    for (int i = m_npos - 1; i >= 0; i--) begin
      d[i] = int'(q % longint'(r[i]));
      q = q / longint'(r[i]);
    end
    e  = la ? d[m_lpos] : 0;
    lw = m_llen[e];
    w  = '0;
    for (int k = 0; k < OUT_CHARS; k++) begin
      c = 0;
      if (!la || k < m_lpos) j = k;
      else if (k < m_lpos + lw) begin j = -1; c = m_lch[e][k - m_lpos]; end
      else j = k - lw + 1;
      if (j >= 0 && j < m_npos) c = m_rch[j][d[j]];
      w[k*CHAR_W +: CHAR_W] = c[CHAR_W-1:0];
    end
    return w;
  endfunction

  task automatic cfg_wr(int k, int s, logic [31:0] d);
    @(posedge clk); #1;
    we = 1'b1; kind = k[2:0]; sel = s[7:0]; data = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic load_range(int pos, string s);
    for (int i = 0; i < s.len(); i++) begin
      m_rch[pos][i] = s[i];
      cfg_wr(0, pos*16 + i, 32'(s[i]));
    end
    m_rlen[pos] = s.len();
    cfg_wr(1, pos, 32'(s.len()));
  endtask

  task automatic load_list(int ent, string s);
    for (int i = 0; i < s.len(); i++) begin
      m_lch[ent][i] = s[i];
      cfg_wr(2, ent*8 + i, 32'(s[i]));
    end
    m_llen[ent] = s.len();
    cfg_wr(3, ent, 32'(s.len()));
  endtask

  task automatic set_shape(int n, int lp, int en, int lc);
    m_npos = n; m_lpos = lp; m_len = en; m_lcnt = lc;
    cfg_wr(4, 0, 32'(n) | (32'(lp) << 8) | (32'(en) << 16) | (32'(lc) << 24));
  endtask

  task automatic run_job(string t, longint unsigned start, int count, bit chk_rate, bit poke);
    int cyc;
    tag = t;
    for (int n = 0; n < count; n++) exp_q.push_back('{model_word(start + longint'(n)), n == count - 1});
    cfg_wr(5, 0, start[31:0]);
    cfg_wr(6, 0, 32'(count));
    cfg_wr(7, 0, 32'd0);
    if (chk_rate) begin
      cyc = 0;
      while (!valid) @(negedge clk);
      while (valid) begin cyc++; @(negedge clk); end
      check("R1", cyc == count, "consecutive valid cycles", 64'(cyc), 64'(count));
    end
    if (poke) begin
      while (!valid) @(negedge clk);
      // R9: none of these may take effect
      cfg_wr(0, 0, 32'h51);
      cfg_wr(4, 0, 32'h0000_0002);
      cfg_wr(5, 0, 32'd9);
      cfg_wr(7, 0, 32'd0);
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R6", !valid, "valid low after final word", 64'(valid), 64'd0);
  endtask

  // scoreboard monitor
  logic prev_hold = 1'b0;
  logic [WORD_W-1:0] prev_w;
  logic prev_l;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_hold)
        check("R2", valid && word == prev_w && last == prev_l, "word held while stalled",
              64'(word), 64'(prev_w));
      prev_hold = valid && !ready;
      prev_w = word;
      prev_l = last;
      if (valid && ready) begin
        if (exp_q.size() == 0) check(tag, 1'b0, "unexpected word", 64'(word), 64'd0);
        else begin
          exp_t x;
          x = exp_q.pop_front();
          check(tag, word == x.w, "candidate word", 64'(word), 64'(x.w));
          check("R6", last == x.l, "last flag", 64'(last), 64'(x.l));
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      ready = (ready_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL R1 watchdog: actual=hung expected=complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    bit seen;
    for (int p = 0; p < NUM_POS; p++) begin
      m_rlen[p] = 0;
      for (int s = 0; s < RANGE_DEPTH; s++) m_rch[p][s] = 0;
    end
    for (int e = 0; e < LIST_DEPTH; e++) begin
      m_llen[e] = 0;
      for (int c = 0; c < LIST_CHARS; c++) m_lch[e][c] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    check("R10", valid == 1'b0 && last == 1'b0, "reset outputs", 64'({valid, last}), 64'd0);
    rst_n = 1'b1;

    ready_mode = 0;
    load_range(0, "ab");
    load_range(1, "xyz");
    load_range(2, "0123");
    set_shape(3, 0, 0, 0);
    run_job("R3", 0, 26, 1, 0);          // full keyspace plus wrap
    run_job("R5", 22, 5, 0, 0);          // start near end, wraps
    run_job("R5", 100, 3, 0, 0);         // start beyond keyspace
    run_job("R6", 7, 1, 0, 0);           // single candidate is also last

    load_range(3, "!~");
    set_shape(4, 0, 0, 0);
    run_job("R4", 40, 16, 0, 0);

    ready_mode = 1;
    run_job("R2", 5, 30, 0, 0);

    load_list(0, "pw");
    load_list(1, "secret");
    load_list(2, "12345678");
    load_list(3, "");
    set_shape(3, 1, 1, 4);
    run_job("R8", 0, 32, 0, 0);
    set_shape(3, 2, 1, 3);
    run_job("R8", 3, 20, 0, 0);

    ready_mode = 0;
    set_shape(3, 0, 0, 0);
    run_job("R9", 2, 24, 0, 1);
    run_job("R9", 0, 5, 0, 0);

    tag = "R7";
    cfg_wr(6, 0, 32'd0);
    cfg_wr(7, 0, 32'd0);
    seen = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (valid) seen = 1'b1;
    end
    check("R7", !seen, "no output for zero count", 64'(seen), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule